// File: doc/BRIEF.md
# Prioritised Edge/Level Interrupt Controller

The block gathers a parameterised set of interrupt lines (32 by default) into two processor request outputs, a normal output and a fast output. Each line carries a packed configuration word: a 5-bit priority, a sensitivity bit choosing edge or level capture, and a routing bit choosing the fast or the normal class. A line whose pending bit is set and whose mask bit is clear becomes a candidate for its class. Among the candidates of a class, the smallest priority value wins. When two candidates share a priority, the higher line number wins.

Each class is a two-state machine, ARMED or FIRED. The transition ARMED→FIRED happens when a candidate exists. On that edge the output asserts and the winning line number is latched into the class's active-line register. The transition FIRED→ARMED happens on a rearm write; the output drops and the class is evaluated again on the next cycle. ARMED stays in ARMED while there is no candidate, and FIRED stays in FIRED until a rearm arrives. Software reads the active-line register to learn the winner, and that read acknowledges an edge line.

A software trigger register raises one line as if its input had asserted. The build parameter `LEVEL_ONLY` forces every line to level sensitivity. Register reads return data one cycle after the access.

Top module: `pri_intc`

Register map, word offsets on `bus_addr`:

| Offset | Register |
|---|---|
| 0x00 | pending bits |
| 0x04 | mask |
| 0x10 | normal active line |
| 0x14 | fast active line |
| 0x18 | rearm control |
| 0x1C + 4·n | configuration of line n |
| 0x9C | software trigger |

## Requirements
- R1: After reset both outputs are low, the mask (offset 0x04) reads all ones, the pending bits (offset 0x00) read zero, every line configuration reads zero, and both classes are ARMED.
- R2: The configuration word of line n sits at offset 0x1C+4·n. Bits [6:2] hold the priority, bit 1 the sensitivity (1 = level, 0 = edge) and bit 0 the routing (1 = fast). A read returns exactly these seven bits with all higher bits zero.
- R3: An edge line sets its pending bit only on an inactive-to-active transition of its input. The bit stays set after the input falls. A held-high input does not set it again after it is cleared.
- R4: A level line is pending whenever its input is high, and its pending bit clears when the input falls. A clearing write to offset 0x00 does not remove a level line whose input is still high.
- R5: A write to offset 0x00 clears every pending bit whose written value is 0 and leaves bits written as 1 unchanged.
- R6: A class output asserts two clock edges after a line of that class becomes pending, provided the class is ARMED and the line is unmasked (the pending bit registers on the first edge, the class fires on the second). On firing, the class latches the line with the smallest priority value; on a tie, the higher line number wins.
- R7: A read of 0x10 (normal) or 0x14 (fast) returns the latched line number of that class. If that line is edge sensitive, its pending bit is cleared. A level line stays pending.
- R8: A write to 0x18 with bit 0 set rearms the normal class and bit 1 rearms the fast class. The rearmed output drops, and it asserts again on the following cycle if a candidate remains.
- R9: A masked pending line (mask bit 1) never causes an output. Clearing its mask bit lets the class fire.
- R10: A write to 0x9C sets the pending bit of the lowest-numbered set bit of the written value only.
- R11: Offsets 0x18, 0x9C and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_in | input | NUM_LINES | Interrupt request lines, active high |
| irq_norm_o | output | 1 | Normal-class request to the processor |
| irq_fast_o | output | 1 | Fast-class request to the processor |

## Verification
The hardest situation to reach is a tie inside one class that is resolved over several rounds. Three equally eligible lines are needed, two of them sharing the best priority. They must become pending on the same edge while the class is ARMED, so that one evaluation sees all three. The stimulus unmasks the lines first and then pulses all three inputs at one negative edge. It then alternates active-line reads, which acknowledge the edge winner, with rearm writes. The winner sequence must come out as tie-winner, tie-loser, then the low-priority line, followed by silence.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic {
        CLS_ARMED = 1'b0,
        CLS_FIRED = 1'b1
    } cls_state_e;

    localparam int NUM_CLASSES = 2;
    localparam int CLS_NORM    = 0;
    localparam int CLS_FAST    = 1;

    localparam logic [7:0] OFS_PEND  = 8'h00;
    localparam logic [7:0] OFS_MASK  = 8'h04;
    localparam logic [7:0] OFS_ACT_N = 8'h10;
    localparam logic [7:0] OFS_ACT_F = 8'h14;
    localparam logic [7:0] OFS_REARM = 8'h18;
    localparam logic [7:0] OFS_CFG0  = 8'h1C;
    localparam logic [7:0] OFS_SWT   = 8'h9C;
endpackage

// File: rtl/intc_pend.sv
module intc_pend #(
    parameter int NUM_LINES = 32,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic [NUM_LINES-1:0] level_i,
    input  logic                 wr_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    input  logic                 ack_i,
    input  logic [ID_W-1:0]      ack_line_i,
    input  logic                 swt_i,
    input  logic [NUM_LINES-1:0] swt_vec_i,
    output logic [NUM_LINES-1:0] pend_o
);
    logic [NUM_LINES-1:0] in_q;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] rise, fall, sw_hit, ack_vec, set_v, clr_v;

    always_comb begin
        rise    = line_i & ~in_q;
        fall    = ~line_i & in_q;
        sw_hit  = swt_i ? (swt_vec_i & (~swt_vec_i + NUM_LINES'(1))) : '0;
        ack_vec = ack_i ? (NUM_LINES'(1) << ack_line_i) : '0;
        set_v   = (level_i & line_i) | (~level_i & rise) | sw_hit;
        clr_v   = (wr_i ? (~wdata_i & ~(level_i & line_i)) : '0)
                | (ack_vec & ~level_i)
                | (level_i & fall);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q   <= '0;
            pend_q <= '0;
        end else begin
            in_q   <= line_i;
            pend_q <= (pend_q & ~clr_v) | set_v;
        end
    end

    assign pend_o = pend_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        assert_edge_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (line_i[g] && !in_q[g] && !level_i[g]) |=> pend_o[g]);
        assert_level_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (level_i[g] && in_q[g] && !line_i[g] && !sw_hit[g]) |=> !pend_o[g]);
    end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 5,
    parameter int ID_W      = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]             cand_i,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_i,
    output logic                             any_o,
    output logic [ID_W-1:0]                  win_o
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        best  = '1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand_i[i] && (prio_i[i] <= best)) begin
                best  = prio_i[i];
                win_o = ID_W'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intc_class.sv
module intc_class
    import intc_pkg::*;
#(
    parameter int ID_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cand_any_i,
    input  logic [ID_W-1:0] win_i,
    input  logic            rearm_i,
    output logic            irq_o,
    output logic [ID_W-1:0] act_o
);
    cls_state_e state_q, state_d;
    logic [ID_W-1:0] act_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLS_ARMED: if (cand_any_i) state_d = CLS_FIRED;
            CLS_FIRED: if (rearm_i)    state_d = CLS_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CLS_ARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (state_q == CLS_ARMED && cand_any_i) begin
            act_q <= win_i;
        end
    end

    assign irq_o = (state_q == CLS_FIRED);
    assign act_o = act_q;

    assert_fire_needs_cand_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(cand_any_i));
    assert_fire_latches_win_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> act_o == $past(win_i));
    assert_hold_until_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !rearm_i) |=> irq_o);
    assert_drop_by_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(rearm_i));
endmodule

// File: rtl/pri_intc.sv
module pri_intc
    import intc_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int PRIO_W     = 5,
    parameter bit LEVEL_ONLY = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 irq_norm_o,
    output logic                 irq_fast_o
);
    localparam int ID_W    = $clog2(NUM_LINES);
    localparam int CFG_END = 28 + 4 * NUM_LINES;

    logic [NUM_LINES-1:0]             mask_q, fast_q, sens, pend;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
    logic [31:0]                      rd_val, rdata_q;
    logic                             wr_en, rd_en, cfg_hit;
    logic [ID_W-1:0]                  cfg_idx;
    logic [NUM_CLASSES-1:0]           rearm, cls_any, cls_irq;
    logic [NUM_CLASSES-1:0][ID_W-1:0] cls_win, cls_act;
    logic [NUM_CLASSES-1:0][NUM_LINES-1:0] cls_cand;
    logic                             ack;
    logic [ID_W-1:0]                  ack_line;

    assign wr_en   = bus_sel && bus_we;
    assign rd_en   = bus_sel && !bus_we;
    assign cfg_hit = (int'(bus_addr) >= int'(OFS_CFG0)) && (int'(bus_addr) < CFG_END)
                     && (bus_addr[1:0] == 2'b00);
    assign cfg_idx = ID_W'((bus_addr - OFS_CFG0) >> 2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            fast_q <= '0;
            prio_q <= '0;
        end else if (wr_en) begin
            if (bus_addr == OFS_MASK) mask_q <= bus_wdata[NUM_LINES-1:0];
            if (cfg_hit) begin
                prio_q[cfg_idx] <= bus_wdata[PRIO_W+1:2];
                fast_q[cfg_idx] <= bus_wdata[0];
            end
        end
    end

    if (LEVEL_ONLY) begin : g_sens_fixed
        assign sens = '1;
    end else begin : g_sens_reg
        logic [NUM_LINES-1:0] sens_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                sens_q <= '0;
            else if (wr_en && cfg_hit) sens_q[cfg_idx] <= bus_wdata[1];
        end
        assign sens = sens_q;
    end

    assign rearm[CLS_NORM] = wr_en && (bus_addr == OFS_REARM) && bus_wdata[0];
    assign rearm[CLS_FAST] = wr_en && (bus_addr == OFS_REARM) && bus_wdata[1];

    always_comb begin
        ack      = 1'b0;
        ack_line = '0;
        if (rd_en && bus_addr == OFS_ACT_N) begin
            ack      = 1'b1;
            ack_line = cls_act[CLS_NORM];
        end else if (rd_en && bus_addr == OFS_ACT_F) begin
            ack      = 1'b1;
            ack_line = cls_act[CLS_FAST];
        end
    end

    intc_pend #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (irq_in),
        .level_i    (sens),
        .wr_i       (wr_en && bus_addr == OFS_PEND),
        .wdata_i    (bus_wdata[NUM_LINES-1:0]),
        .ack_i      (ack),
        .ack_line_i (ack_line),
        .swt_i      (wr_en && bus_addr == OFS_SWT),
        .swt_vec_i  (bus_wdata[NUM_LINES-1:0]),
        .pend_o     (pend)
    );

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        assign cls_cand[c] = pend & ~mask_q & ((c == CLS_FAST) ? fast_q : ~fast_q);

        intc_pick #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
            .cand_i (cls_cand[c]),
            .prio_i (prio_q),
            .any_o  (cls_any[c]),
            .win_o  (cls_win[c])
        );

        intc_class #(.ID_W(ID_W)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .cand_any_i (cls_any[c]),
            .win_i      (cls_win[c]),
            .rearm_i    (rearm[c]),
            .irq_o      (cls_irq[c]),
            .act_o      (cls_act[c])
        );
    end

    always_comb begin
        rd_val = '0;
        if (cfg_hit) begin
            rd_val = 32'({prio_q[cfg_idx], sens[cfg_idx], fast_q[cfg_idx]});
        end else begin
            unique case (bus_addr)
                OFS_PEND:  rd_val = 32'(pend);
                OFS_MASK:  rd_val = 32'(mask_q);
                OFS_ACT_N: rd_val = 32'(cls_act[CLS_NORM]);
                OFS_ACT_F: rd_val = 32'(cls_act[CLS_FAST]);
                default:   rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_val;
    end

    assign bus_rdata  = rdata_q;
    assign irq_norm_o = cls_irq[CLS_NORM];
    assign irq_fast_o = cls_irq[CLS_FAST];

    assert_masked_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_norm_o) |-> !$past(mask_q[cls_win[CLS_NORM]]));
    assert_class_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_fast_o) |-> $past(fast_q[cls_win[CLS_FAST]]));
endmodule

// File: tb/pri_intc_tb.sv
module pri_intc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic        irq_norm_o, irq_fast_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic rd_pending = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    pri_intc u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_in     (irq_in),
        .irq_norm_o (irq_norm_o),
        .irq_fast_o (irq_fast_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        rd_pending <= bus_sel & ~bus_we;
        cycles     <= cycles + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each completed read
    always @(negedge clk) begin
        if (rd_pending) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL scoreboard actual=%h expected=<none>", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk); irq_in = v;
        @(negedge clk); irq_in = '0;
        wait_cyc(3);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        chk("R1 irq_norm", 32'(irq_norm_o), 0);
        chk("R1 irq_fast", 32'(irq_fast_o), 0);
        bus_rd(8'h04, 32'hFFFF_FFFF, "R1 mask");
        bus_rd(8'h00, 32'h0, "R1 pending");
        bus_rd(8'h30, 32'h0, "R1 cfg5");

        // R2 config packing
        bus_wr(8'h28, 32'h0000_001F);
        bus_rd(8'h28, 32'h0000_001F, "R2 cfg3");
        bus_wr(8'h98, 32'hFFFF_FFFF);
        bus_rd(8'h98, 32'h0000_007F, "R2 cfg31");
        bus_wr(8'h28, 32'h0);
        bus_wr(8'h98, 32'h0);

        // R3 edge capture
        @(negedge clk); irq_in = 32'h10;
        wait_cyc(3);
        bus_rd(8'h00, 32'h10, "R3 rise");
        @(negedge clk); irq_in = 32'h0;
        wait_cyc(2);
        bus_rd(8'h00, 32'h10, "R3 held");
        @(negedge clk); irq_in = 32'h10;
        wait_cyc(2);
        bus_wr(8'h00, 32'h0);
        wait_cyc(2);
        bus_rd(8'h00, 32'h0, "R3 no recapture");
        @(negedge clk); irq_in = 32'h0;

        // R4 level
        bus_wr(8'h34, 32'h2);
        @(negedge clk); irq_in = 32'h40;
        wait_cyc(3);
        bus_rd(8'h00, 32'h40, "R4 level set");
        bus_wr(8'h00, 32'h0);
        bus_rd(8'h00, 32'h40, "R4 level kept");
        @(negedge clk); irq_in = 32'h0;
        wait_cyc(2);
        bus_rd(8'h00, 32'h0, "R4 level drop");

        // R5 pending write
        pulse(32'h6);
        bus_rd(8'h00, 32'h6, "R5 two pending");
        bus_wr(8'h00, 32'h2);
        bus_rd(8'h00, 32'h2, "R5 partial clear");
        bus_wr(8'h00, 32'h0);
        bus_rd(8'h00, 32'h0, "R5 all clear");

        // R9 mask gating, R6 firing
        pulse(32'h100);
        chk("R9 masked silent", 32'(irq_norm_o), 0);
        bus_wr(8'h04, ~32'h100);
        wait_cyc(3);
        chk("R9 unmask fires", 32'(irq_norm_o), 1);
        chk("R6 fast idle", 32'(irq_fast_o), 0);

        // R7 active read acknowledges edge
        bus_rd(8'h10, 32'd8, "R7 active normal");
        bus_rd(8'h00, 32'h0, "R7 edge acked");
        chk("R8 held until rearm", 32'(irq_norm_o), 1);
        bus_wr(8'h18, 32'h1);
        wait_cyc(3);
        chk("R8 rearm drops", 32'(irq_norm_o), 0);

        // R6 priority and tie, R8 refire
        bus_wr(8'h44, 32'h0C);
        bus_wr(8'h4C, 32'h04);
        bus_wr(8'h54, 32'h04);
        bus_wr(8'h04, ~32'h0000_5500);
        pulse(32'h0000_5400);
        chk("R6 fired", 32'(irq_norm_o), 1);
        bus_rd(8'h10, 32'd14, "R6 tie higher line");
        bus_wr(8'h18, 32'h1);
        wait_cyc(3);
        chk("R8 refire", 32'(irq_norm_o), 1);
        bus_rd(8'h10, 32'd12, "R6 second winner");
        bus_wr(8'h18, 32'h1);
        wait_cyc(3);
        bus_rd(8'h10, 32'd10, "R6 low priority last");
        bus_wr(8'h18, 32'h1);
        wait_cyc(3);
        chk("R8 no candidate", 32'(irq_norm_o), 0);

        // R7 level line not acknowledged
        bus_wr(8'h04, ~32'h0000_5540);
        @(negedge clk); irq_in = 32'h40;
        wait_cyc(3);
        chk("R7 level fires", 32'(irq_norm_o), 1);
        bus_rd(8'h10, 32'd6, "R7 level active");
        bus_rd(8'h00, 32'h40, "R7 level stays");
        @(negedge clk); irq_in = 32'h0;
        wait_cyc(2);
        bus_wr(8'h18, 32'h1);
        wait_cyc(3);
        chk("R8 quiet after level", 32'(irq_norm_o), 0);

        // fast class, R6 routing, R8 fast rearm
        bus_wr(8'h6C, 32'h09);
        bus_wr(8'h04, ~32'h0010_5540);
        pulse(32'h0010_0000);
        chk("R6 fast fires", 32'(irq_fast_o), 1);
        chk("R6 normal untouched", 32'(irq_norm_o), 0);
        bus_rd(8'h14, 32'd20, "R7 active fast");
        bus_rd(8'h00, 32'h0, "R7 fast acked");
        bus_wr(8'h18, 32'h2);
        wait_cyc(3);
        chk("R8 fast rearm", 32'(irq_fast_o), 0);

        // R10 software trigger
        bus_wr(8'h9C, 32'h00A0_0000);
        bus_rd(8'h00, 32'h0020_0000, "R10 lowest bit");
        chk("R10 masked no fire", 32'(irq_norm_o), 0);
        bus_wr(8'h00, 32'h0);

        // R11 zero reads
        bus_rd(8'h18, 32'h0, "R11 rearm reads 0");
        bus_rd(8'h9C, 32'h0, "R11 trigger reads 0");
        bus_rd(8'h08, 32'h0, "R11 unmapped 08");
        bus_rd(8'hFC, 32'h0, "R11 unmapped FC");

        wait_cyc(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(negedge clk) begin
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule